// File: doc/BRIEF.md
# Configurable Trigger-Mode Interrupt Controller

This block collects a parameterised set of interrupt sources (32 by default) and turns them into two request lines and one wake line. Each source has its own trigger mode, built from three separate mode bit-planes: off, rising edge, falling edge, either edge, high level or low level. Edges are held in sticky latches until software clears them. Level sources follow the synchronised input directly. A per-source routing bit picks the request line. A mask bit gates the source onto that line, and a wake-enable bit gates the source onto the wake line without regard to the mask.

All state sits behind a simple single-cycle register port. Each control register has three addresses: one to read it, one that sets the bits written as 1, and one that clears them. Software can therefore change one source without a read-modify-write, and can save and restore the whole state. Read data is registered and appears one cycle after the address.

The address map, in word units on `bus_addr`, is as follows. Control register k (0 mode bit 0, 1 mode bit 1, 2 mode bit 2, 3 source-select, 4 routing, 5 wake-enable, 6 mask) is read at 4k, set at 4k+1 and cleared at 4k+2. The rising latch reads at 28 and clears at 29. The falling latch reads at 30 and clears at 31. The line-0 status reads at 32 and the line-1 status at 33. The test bit reads at 34 and is written at 35, from `bus_wdata[0]`.

Top module: `trig_intc`

## Requirements
- R1: The mode of source i is {mode2[i], mode1[i], mode0[i]}: 000 off, 001 rising edge, 010 falling edge, 011 either edge, 101 active-high level, 110 active-low level. The codes 100 and 111 act as off.
- R2: A write to a set address ORs the write data into its register, and a write to a clear address removes the bits written as 1. Bits written as 0 keep their value.
- R3: Each of the seven control registers, both edge latches, both status registers and the test bit can be read at the address listed above, with one cycle of read latency.
- R4: A pending, unmasked source whose routing bit is 1 raises `req0_o`. One whose routing bit is 0 raises `req1_o`.
- R5: The status register of a line holds, per source, pending AND mask AND routed to that line.
- R6: The rising latch bit is set on a synchronised rising edge when the mode is 001 or 011. The falling latch bit is set on a falling edge when the mode is 010 or 011. A latch bit stays set until a 1 is written to its clear address, and a source in an edge mode is pending while its matching latch is set.
- R7: A source whose mask bit is 0 never drives either request line, but its edge latches still capture.
- R8: `wake_o` is the OR over all sources of pending AND wake-enable, independent of the mask.
- R9: While the test bit is 1, every source whose mode is valid (not off) counts as pending.
- R10: A level-mode source is pending exactly while its synchronised input is at the active level, with no latching.
- R11: After reset the mode, mask, wake-enable, latch and test bits are 0, the routing and source-select bits are all 1, and all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NSRC | Raw asynchronous source inputs |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Registered read data |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wake line |

## Verification
The bench targets the mode codes 100 and 111. A decoder that keyed on single bits would report these as level sources and raise a request. It checks that an edge stays pending after the input returns to idle, which a design that fed the edge pulse straight through would drop. It also checks that clearing the latch ends the request.

A masked falling-edge source is toggled and then unmasked. A design that gated latch capture with the mask would then show no request. Wake is checked with the mask off, and the test bit is checked on an edge source with no edge seen. Together these catch a wake path tied to the mask and a test force that misses unlatched edge sources.

// File: rtl/trig_intc_pkg.sv
package trig_intc_pkg;
  localparam int NREG     = 7;
  localparam int R_MODE0  = 0;
  localparam int R_MODE1  = 1;
  localparam int R_MODE2  = 2;
  localparam int R_SRCSEL = 3;
  localparam int R_ROUTE  = 4;
  localparam int R_WAKE   = 5;
  localparam int R_MASK   = 6;
  localparam int A_RISE_RD = 28;
  localparam int A_RISE_CL = 29;
  localparam int A_FALL_RD = 30;
  localparam int A_FALL_CL = 31;
  localparam int A_STAT0   = 32;
  localparam int A_STAT1   = 33;
  localparam int A_TEST_RD = 34;
  localparam int A_TEST_WR = 35;

  typedef enum logic [2:0] {
    M_OFF  = 3'b000,
    M_RISE = 3'b001,
    M_FALL = 3'b010,
    M_BOTH = 3'b011,
    M_HIGH = 3'b101,
    M_LOW  = 3'b110
  } trig_mode_e;
endpackage

// File: rtl/trig_intc_sync.sv
module trig_intc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise_ev,
  output logic [W-1:0] fall_ev
);
  logic [W-1:0] meta_q, stab_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  assign lvl     = stab_q;
  assign rise_ev = stab_q & ~prev_q;
  assign fall_ev = ~stab_q & prev_q;
endmodule

// File: rtl/trig_intc_regs.sv
module trig_intc_regs
  import trig_intc_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  rise_ev,
  input  logic [W-1:0]  fall_ev,
  input  logic [W-1:0]  stat0,
  input  logic [W-1:0]  stat1,
  output logic [W-1:0]  mode0,
  output logic [W-1:0]  mode1,
  output logic [W-1:0]  mode2,
  output logic [W-1:0]  route,
  output logic [W-1:0]  wake_en,
  output logic [W-1:0]  mask,
  output logic [W-1:0]  rise_q,
  output logic [W-1:0]  fall_q,
  output logic          test_q,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] ctl_q [NREG];
  logic [W-1:0] rd_next;
  logic [W-1:0] rise_cap, fall_cap;

  genvar r;
  generate
    for (r = 0; r < NREG; r++) begin : g_ctl
      localparam logic [AW-1:0] A_SET = AW'(4 * r + 1);
      localparam logic [AW-1:0] A_CLR = AW'(4 * r + 2);
      localparam logic [W-1:0]  RST_V = (r == R_ROUTE || r == R_SRCSET_IDX(r)) ? '1 : '0;
      always_ff @(posedge clk) begin
        if (rst) ctl_q[r] <= RST_V;
        else if (we && addr == A_SET) ctl_q[r] <= ctl_q[r] | wdata;
        else if (we && addr == A_CLR) ctl_q[r] <= ctl_q[r] & ~wdata;
      end

      p_set_r2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_SET) |=> ((ctl_q[r] & $past(wdata)) == $past(wdata)) &&
                                   ((ctl_q[r] & ~$past(wdata)) == ($past(ctl_q[r]) & ~$past(wdata))));
      p_clr_r2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_CLR) |=> ((ctl_q[r] & $past(wdata)) == '0) &&
                                   ((ctl_q[r] & ~$past(wdata)) == ($past(ctl_q[r]) & ~$past(wdata))));
    end
  endgenerate

  function automatic int R_SRCSET_IDX(input int k);
    return (k == R_SRCSEL) ? k : -1;
  endfunction

  assign mode0   = ctl_q[R_MODE0];
  assign mode1   = ctl_q[R_MODE1];
  assign mode2   = ctl_q[R_MODE2];
  assign route   = ctl_q[R_ROUTE];
  assign wake_en = ctl_q[R_WAKE];
  assign mask    = ctl_q[R_MASK];

  // rising capture for modes 001/011, falling for 010/011
  assign rise_cap = rise_ev & mode0 & ~mode2;
  assign fall_cap = fall_ev & mode1 & ~mode2;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
      test_q <= 1'b0;
    end else begin
      rise_q <= (rise_q & ~((we && addr == AW'(A_RISE_CL)) ? wdata : '0)) | rise_cap;
      fall_q <= (fall_q & ~((we && addr == AW'(A_FALL_CL)) ? wdata : '0)) | fall_cap;
      if (we && addr == AW'(A_TEST_WR)) test_q <= wdata[0];
    end
  end

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == AW'(A_RISE_CL)) |=> ((rise_q & $past(rise_q)) == $past(rise_q)));
  p_fall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == AW'(A_FALL_CL)) |=> ((fall_q & $past(fall_q)) == $past(fall_q)));

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NREG; k++)
      if (addr == AW'(4 * k)) rd_next = ctl_q[k];
    case (int'(addr))
      A_RISE_RD: rd_next = rise_q;
      A_FALL_RD: rd_next = fall_q;
      A_STAT0:   rd_next = stat0;
      A_STAT1:   rd_next = stat1;
      A_TEST_RD: rd_next = {{(W-1){1'b0}}, test_q};
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/trig_intc_detect.sv
module trig_intc_detect
  import trig_intc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] mode0,
  input  logic [W-1:0] mode1,
  input  logic [W-1:0] mode2,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_q,
  input  logic [W-1:0] fall_q,
  input  logic         test,
  output logic [W-1:0] pend
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_src
      trig_mode_e md;
      logic       hit, valid;
      assign md = trig_mode_e'({mode2[i], mode1[i], mode0[i]});
      always_comb begin
        hit   = 1'b0;
        valid = 1'b1;
        case (md)
          M_RISE: hit = rise_q[i];
          M_FALL: hit = fall_q[i];
          M_BOTH: hit = rise_q[i] | fall_q[i];
          M_HIGH: hit = lvl[i];
          M_LOW:  hit = ~lvl[i];
          default: valid = 1'b0;
        endcase
      end
      assign pend[i] = valid & (hit | test);
    end
  endgenerate
endmodule

// File: rtl/trig_intc.sv
module trig_intc #(
  parameter int NSRC = 32,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_in,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            req0_o,
  output logic            req1_o,
  output logic            wake_o
);
  logic [NSRC-1:0] lvl, rise_ev, fall_ev;
  logic [NSRC-1:0] mode0, mode1, mode2, route, wake_en, mask;
  logic [NSRC-1:0] rise_q, fall_q, pend, stat0, stat1;
  logic            test_q;
  logic            req0_q, req1_q, wake_q;

  trig_intc_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst(rst), .raw(irq_in),
    .lvl(lvl), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  trig_intc_regs #(.W(NSRC), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .stat0(stat0), .stat1(stat1),
    .mode0(mode0), .mode1(mode1), .mode2(mode2), .route(route),
    .wake_en(wake_en), .mask(mask), .rise_q(rise_q), .fall_q(fall_q),
    .test_q(test_q), .rdata(bus_rdata)
  );

  trig_intc_detect #(.W(NSRC)) u_det (
    .mode0(mode0), .mode1(mode1), .mode2(mode2), .lvl(lvl),
    .rise_q(rise_q), .fall_q(fall_q), .test(test_q), .pend(pend)
  );

  assign stat0 = pend & mask & route;
  assign stat1 = pend & mask & ~route;

  always_ff @(posedge clk) begin
    if (rst) begin
      req0_q <= 1'b0;
      req1_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      req0_q <= |stat0;
      req1_q <= |stat1;
      wake_q <= |(pend & wake_en);
    end
  end

  assign req0_o = req0_q;
  assign req1_o = req1_q;
  assign wake_o = wake_q;

  p_masked_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> (!req0_o && !req1_o));
  p_wake_off_r8: assert property (@(posedge clk) disable iff (rst)
    (wake_en == '0) |=> !wake_o);
  p_one_line_r4: assert property (@(posedge clk) disable iff (rst)
    (route == '1) |=> !req1_o);
  p_no_pend_r1: assert property (@(posedge clk) disable iff (rst)
    (mode0 == '0 && mode1 == '0) |=> (!req0_o && !req1_o && !wake_o));
endmodule

// File: tb/trig_intc_bench.sv
module trig_intc_bench;
  localparam int NSRC = 32;
  localparam int AW   = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] irq_in = '0;
  logic            bus_we = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [NSRC-1:0] bus_wdata = '0;
  logic [NSRC-1:0] bus_rdata;
  logic            req0_o, req1_o, wake_o;

  always #10 clk = ~clk;

  trig_intc #(.NSRC(NSRC), .AW(AW)) u_trig_intc (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
  );

  typedef struct {
    int          what;   // 0 req0, 1 req1, 2 wake, 3 rdata
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // monitor: compares queued expectations against live outputs
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.what)
          0: act = {31'b0, req0_o};
          1: act = {31'b0, req1_o};
          2: act = {31'b0, wake_o};
          default: act = bus_rdata;
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int w, input logic [31:0] e, input string t);
    item_t it;
    it.what = w; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = AW'(a);
    @(negedge clk);
    push(3, e, t);
    @(negedge clk);
  endtask

  task automatic outs(input logic r0, input logic r1, input logic wk, input string t);
    repeat (6) @(negedge clk);
    push(0, {31'b0, r0}, {t, " req0"});
    push(1, {31'b0, r1}, {t, " req1"});
    push(2, {31'b0, wk}, {t, " wake"});
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; irq_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // register addresses: control k read 4k, set 4k+1, clear 4k+2
  localparam int M0 = 0, M1 = 4, M2 = 8, SS = 12, RT = 16, WK = 20, MK = 24;

  initial begin
    do_reset();
    // R11 reset state
    push(0, 0, "R11 req0"); push(1, 0, "R11 req1"); push(2, 0, "R11 wake");
    rd(MK, 32'h0, "R11 mask");
    rd(RT, 32'hFFFF_FFFF, "R11 route");
    rd(SS, 32'hFFFF_FFFF, "R11 srcsel");
    rd(34, 32'h0, "R11 test");

    // R2 / R3 set and clear
    wr(MK + 1, 32'h0000_00F0);
    wr(MK + 1, 32'h0000_0003);
    wr(MK + 2, 32'h0000_0030);
    rd(MK, 32'h0000_00C3, "R2 mask set/clear");
    wr(RT + 2, 32'h0000_FFFF);
    rd(RT, 32'hFFFF_0000, "R3 route readback");
    wr(M1 + 1, 32'h8000_0001);
    rd(M1, 32'h8000_0001, "R3 mode1 readback");

    // R10 / R4 / R5 high level on source 3
    do_reset();
    wr(M0 + 1, 32'h8); wr(M2 + 1, 32'h8); wr(MK + 1, 32'h8);
    irq_in[3] = 1'b1;
    outs(1, 0, 0, "R10 high level");
    rd(32, 32'h8, "R5 status0");
    wr(RT + 2, 32'h8);
    outs(0, 1, 0, "R4 routed to line1");
    rd(33, 32'h8, "R5 status1");
    irq_in[3] = 1'b0;
    outs(0, 0, 0, "R10 level released");

    // R10 low level on source 5
    do_reset();
    wr(M1 + 1, 32'h20); wr(M2 + 1, 32'h20); wr(MK + 1, 32'h20);
    outs(1, 0, 0, "R10 low level active");
    irq_in[5] = 1'b1;
    outs(0, 0, 0, "R10 low level idle");

    // R1 invalid codes 100 and 111
    do_reset();
    wr(M2 + 1, 32'h80); wr(MK + 1, 32'h80); wr(WK + 1, 32'h80);
    irq_in[7] = 1'b1;
    outs(0, 0, 0, "R1 code 100 off");
    wr(M0 + 1, 32'h80); wr(M1 + 1, 32'h80);
    outs(0, 0, 0, "R1 code 111 off");

    // R6 rising edge latch on source 2
    do_reset();
    wr(M0 + 1, 32'h4); wr(MK + 1, 32'h4);
    irq_in[2] = 1'b1;
    outs(1, 0, 0, "R6 rise latched");
    irq_in[2] = 1'b0;
    outs(1, 0, 0, "R6 rise held");
    rd(28, 32'h4, "R6 rise latch read");
    rd(30, 32'h0, "R6 fall latch untouched");
    wr(29, 32'h4);
    outs(0, 0, 0, "R6 rise cleared");
    rd(28, 32'h0, "R6 rise latch after clear");

    // R7 masked falling source still captures
    do_reset();
    wr(M1 + 1, 32'h10);
    irq_in[4] = 1'b1;
    repeat (5) @(negedge clk);
    irq_in[4] = 1'b0;
    outs(0, 0, 0, "R7 masked silent");
    rd(30, 32'h10, "R7 fall latch captured");
    rd(28, 32'h0, "R7 rise latch not captured");
    wr(MK + 1, 32'h10);
    outs(1, 0, 0, "R7 unmask shows latched edge");

    // R6 either edge on source 6
    do_reset();
    wr(M0 + 1, 32'h40); wr(M1 + 1, 32'h40);
    irq_in[6] = 1'b1;
    repeat (5) @(negedge clk);
    rd(28, 32'h40, "R6 both rise");
    irq_in[6] = 1'b0;
    repeat (5) @(negedge clk);
    rd(30, 32'h40, "R6 both fall");

    // R8 wake independent of mask
    do_reset();
    wr(M0 + 1, 32'h200); wr(M2 + 1, 32'h200); wr(WK + 1, 32'h200);
    irq_in[9] = 1'b1;
    outs(0, 0, 1, "R8 wake unmasked-independent");
    wr(WK + 2, 32'h200);
    outs(0, 0, 0, "R8 wake disabled");

    // R9 test bit forces valid-mode sources
    do_reset();
    wr(M0 + 1, 32'h400); wr(MK + 1, 32'hC00); wr(RT + 2, 32'h400);
    outs(0, 0, 0, "R9 no edge yet");
    wr(35, 32'h1);
    outs(0, 1, 0, "R9 test forces");
    rd(34, 32'h1, "R9 test readback");
    wr(35, 32'h0);
    outs(0, 0, 0, "R9 test released");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule